// File: doc/BRIEF.md
# Slot-Based Power Rail Sequencer

This block turns eleven rail enable outputs on and off in a programmed order. Time is split into sixteen numbered slots. Each rail carries one slot number for the start-up walk and a separate one for the shut-down walk. Each slot carries a 2-bit wait code, with one table for each direction. A start-up request walks slots 0 to 15 and raises the enables of the rails assigned to each slot. A shut-down request walks slots 0 to 15 with the shut-down tables and lowers them. Rails that share a slot switch in the same clock cycle. The wait code sets only the delay before the next slot is acted on. The block never looks at whether a rail has finished ramping.

The configuration sits behind a plain byte-wide write port and a combinational read port. Requests and status are level/pulse control pins. The block has no data stream, so it has no valid/ready handshake and applies no back-pressure. Waits are counted in prescaled ticks. One tick is `TICK_DIV` clocks, which stands for 0.5 ms in silicon, and a simulation can shorten it.

Rail order on `rail_en`: bits 0 to 2 are the switching regulators, bits 3 to 6 the linear regulators, bits 7 and 8 the general outputs, bit 9 the GPIO and bit 10 the reset line.

Top module: `rail_sequencer`

## Requirements
- R1: After reset every `rail_en` bit is 0 and `seq_state` is OFF. Every slot field and wait code reads back as 0, and `seq_done` is 0.
- R2: Configuration layout. The start-up slot of rail i is at byte address 0x00+i and its shut-down slot at 0x10+i, each in bits 7:4, with bits 3:0 reading 0. Start-up wait codes are at 0x20..0x23 and shut-down wait codes at 0x28..0x2B. Slot 4b+j sits in byte b at bits (7-2j):(6-2j). Unmapped addresses read 0.
- R3: A start-up walk visits slots 0 to 15 in ascending order and sets the enables of all rails whose start-up slot is the visited slot, in one cycle. After slot 15 the state is ON and all enables are 1.
- R4: Wait codes 0, 1, 2 and 3 mean 0, C1, C2 and C3 ticks (defaults 3, 6 and 20, standing for 0, 1.5, 3 and 10 ms). Slot k+1 is acted on exactly 1 + ticks(k)*TICK_DIV cycles after slot k, and the end state is reached that long after slot 15.
- R5: A shut-down walk from ON visits slots 0 to 15 with the shut-down tables and clears each rail when its shut-down slot is visited. It ends in OFF with all enables 0.
- R6: `seq_done` is a single-cycle pulse that is high in the first cycle of ON and in the first cycle of OFF after a walk.
- R7: A shut-down request during a start-up walk lets the current slot's wait run to its end. A shut-down walk then starts from slot 0 instead of the next start-up slot.
- R8: A start-up request in SEQ_DOWN or ON is ignored. A shut-down request in OFF is ignored.
- R9: Configuration writes are ignored unless the state is OFF. Reads work in any state.
- R10: `seq_state` encodes OFF=0, SEQ_UP=1, ON=2, SEQ_DOWN=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_up_req | input | 1 | Start-up request, sampled each cycle |
| pwr_dn_req | input | 1 | Shut-down request, sampled each cycle |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` |
| rail_en | output | 11 | Rail enable outputs |
| seq_state | output | 2 | Sequencer state |
| seq_done | output | 1 | Pulse on reaching ON or OFF |

## Verification
The start-up walk runs with the four wait codes cycled over the slots and with rails spread across scattered slots, two of them sharing slot 0. Measuring each enable edge against the done pulse therefore separates a wrong code-to-tick mapping, an off-by-one slot spacing and slots visited in the wrong order. The shut-down walk runs with a shifted code pattern and a reversed slot map, so that a design reusing the start-up tables would fail. An abort test uses long waits and places the shut-down request inside one slot's wait. It shows whether that wait is honoured and whether later start-up slots stay off. Further requests and writes issued in the wrong states show whether they are properly ignored.

// File: rtl/rseq_pkg.sv
`timescale 1ns/1ps
package rseq_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_UP   = 2'd1,
    ST_ON   = 2'd2,
    ST_DOWN = 2'd3
  } seq_state_e;
endpackage

// File: rtl/rseq_cfg.sv
`timescale 1ns/1ps
module rseq_cfg #(
  parameter int NUM_RAILS = 11,
  parameter int NUM_SLOTS = 16,
  parameter int AW        = 6,
  localparam int SLOT_W    = $clog2(NUM_SLOTS),
  localparam int DUR_BYTES = NUM_SLOTS / 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr,
  input  logic                               wr_allow,
  input  logic [AW-1:0]                      addr,
  input  logic [7:0]                         wdata,
  output logic [7:0]                         rdata,
  output logic [NUM_RAILS-1:0][SLOT_W-1:0]   up_slot,
  output logic [NUM_RAILS-1:0][SLOT_W-1:0]   dn_slot,
  output logic [NUM_SLOTS-1:0][1:0]          up_code,
  output logic [NUM_SLOTS-1:0][1:0]          dn_code
);
  localparam int RAIL_UP_BASE = 'h00;
  localparam int RAIL_DN_BASE = 'h10;
  localparam int UP_DUR_BASE  = 'h20;
  localparam int DN_DUR_BASE  = 'h28;

  logic wr_ok;
  assign wr_ok = wr && wr_allow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_slot <= '0;
      dn_slot <= '0;
      up_code <= '0;
      dn_code <= '0;
    end else if (wr_ok) begin
      for (int r = 0; r < NUM_RAILS; r++) begin
        if (addr == AW'(RAIL_UP_BASE + r)) up_slot[r] <= wdata[7 -: SLOT_W];
        if (addr == AW'(RAIL_DN_BASE + r)) dn_slot[r] <= wdata[7 -: SLOT_W];
      end
      for (int b = 0; b < DUR_BYTES; b++) begin
        for (int j = 0; j < 4; j++) begin
          if (addr == AW'(UP_DUR_BASE + b)) up_code[4*b+j] <= wdata[7-2*j -: 2];
          if (addr == AW'(DN_DUR_BASE + b)) dn_code[4*b+j] <= wdata[7-2*j -: 2];
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int r = 0; r < NUM_RAILS; r++) begin
      if (addr == AW'(RAIL_UP_BASE + r)) rdata[7 -: SLOT_W] = up_slot[r];
      if (addr == AW'(RAIL_DN_BASE + r)) rdata[7 -: SLOT_W] = dn_slot[r];
    end
    for (int b = 0; b < DUR_BYTES; b++) begin
      for (int j = 0; j < 4; j++) begin
        if (addr == AW'(UP_DUR_BASE + b)) rdata[7-2*j -: 2] = up_code[4*b+j];
        if (addr == AW'(DN_DUR_BASE + b)) rdata[7-2*j -: 2] = dn_code[4*b+j];
      end
    end
  end
endmodule

// File: rtl/rseq_timer.sv
`timescale 1ns/1ps
module rseq_timer #(
  parameter int TICK_DIV = 100000,
  parameter int TICK_W   = 5,
  localparam int PRE_W   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TICK_W-1:0] load_ticks,
  output logic              expire
);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [TICK_W-1:0] ticks_left;
  logic [PRE_W-1:0]  pre;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ticks_left <= '0;
      pre        <= '0;
    end else if (load) begin
      ticks_left <= load_ticks;
      pre        <= '0;
    end else if (ticks_left != '0) begin
      if (pre == PRE_LAST) begin
        pre        <= '0;
        ticks_left <= ticks_left - 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  assign expire = (ticks_left == TICK_W'(1)) && (pre == PRE_LAST);
endmodule

// File: rtl/rseq_fsm.sv
`timescale 1ns/1ps
module rseq_fsm
  import rseq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int C1_TICKS  = 3,
  parameter int C2_TICKS  = 6,
  parameter int C3_TICKS  = 20,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int TICK_W   = $clog2(C3_TICKS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      up_req,
  input  logic                      dn_req,
  input  logic [NUM_SLOTS-1:0][1:0] up_code,
  input  logic [NUM_SLOTS-1:0][1:0] dn_code,
  input  logic                      expire,
  output seq_state_e                state,
  output logic [SLOT_W-1:0]         slot,
  output logic                      act,
  output logic                      timer_load,
  output logic [TICK_W-1:0]         load_ticks,
  output logic                      done
);
  logic        in_wait;
  logic        pend_dn;
  logic        walking;
  logic        advance;
  logic [1:0]  cur_code;

  assign walking  = (state == ST_UP) || (state == ST_DOWN);
  assign cur_code = (state == ST_UP) ? up_code[slot] : dn_code[slot];

  always_comb begin
    case (cur_code)
      2'd0:    load_ticks = '0;
      2'd1:    load_ticks = TICK_W'(C1_TICKS);
      2'd2:    load_ticks = TICK_W'(C2_TICKS);
      default: load_ticks = TICK_W'(C3_TICKS);
    endcase
  end

  assign act        = walking && !in_wait;
  assign timer_load = act && (load_ticks != '0);
  assign advance    = act ? (load_ticks == '0) : (walking && in_wait && expire);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_OFF;
      slot    <= '0;
      in_wait <= 1'b0;
      pend_dn <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_OFF: if (up_req) begin
          state   <= ST_UP;
          slot    <= '0;
          in_wait <= 1'b0;
          pend_dn <= 1'b0;
        end
        ST_ON: if (dn_req) begin
          state   <= ST_DOWN;
          slot    <= '0;
          in_wait <= 1'b0;
        end
        default: begin
          if (state == ST_UP && dn_req) pend_dn <= 1'b1;
          if (act && !advance) in_wait <= 1'b1;
          if (advance) begin
            in_wait <= 1'b0;
            if (state == ST_UP && (pend_dn || dn_req)) begin
              state   <= ST_DOWN;
              slot    <= '0;
              pend_dn <= 1'b0;
            end else if (slot == SLOT_W'(NUM_SLOTS - 1)) begin
              state <= (state == ST_UP) ? ST_ON : ST_OFF;
              slot  <= '0;
              done  <= 1'b1;
            end else begin
              slot <= slot + 1'b1;
            end
          end
        end
      endcase
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R6
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state == ST_ON || state == ST_OFF));  // R6
  AST_WAIT_ONLY_WALKING: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> walking);  // R4
  AST_ABORT_HOLDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_UP && in_wait && !expire) |=> (state == ST_UP));  // R7
  AST_UP_IGNORED_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DOWN && up_req) |=> (state != ST_UP));  // R8
endmodule

// File: rtl/rail_sequencer.sv
`timescale 1ns/1ps
module rail_sequencer
  import rseq_pkg::*;
#(
  parameter int NUM_RAILS = 11,
  parameter int NUM_SLOTS = 16,
  parameter int TICK_DIV  = 100000,
  parameter int C1_TICKS  = 3,
  parameter int C2_TICKS  = 6,
  parameter int C3_TICKS  = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwr_up_req,
  input  logic                 pwr_dn_req,
  input  logic                 cfg_wr,
  input  logic [5:0]           cfg_addr,
  input  logic [7:0]           cfg_wdata,
  output logic [7:0]           cfg_rdata,
  output logic [NUM_RAILS-1:0] rail_en,
  output logic [1:0]           seq_state,
  output logic                 seq_done
);
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int TICK_W = $clog2(C3_TICKS + 1);

  logic [NUM_RAILS-1:0][SLOT_W-1:0] up_slot, dn_slot;
  logic [NUM_SLOTS-1:0][1:0]        up_code, dn_code;
  seq_state_e                       state;
  logic [SLOT_W-1:0]                slot;
  logic                             act, timer_load, expire;
  logic [TICK_W-1:0]                load_ticks;

  rseq_cfg #(.NUM_RAILS(NUM_RAILS), .NUM_SLOTS(NUM_SLOTS), .AW(6)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wr_allow(state == ST_OFF),
    .addr(cfg_addr), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .up_slot(up_slot), .dn_slot(dn_slot), .up_code(up_code), .dn_code(dn_code));

  rseq_fsm #(.NUM_SLOTS(NUM_SLOTS), .C1_TICKS(C1_TICKS), .C2_TICKS(C2_TICKS),
             .C3_TICKS(C3_TICKS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .up_req(pwr_up_req), .dn_req(pwr_dn_req),
    .up_code(up_code), .dn_code(dn_code), .expire(expire),
    .state(state), .slot(slot), .act(act), .timer_load(timer_load),
    .load_ticks(load_ticks), .done(seq_done));

  rseq_timer #(.TICK_DIV(TICK_DIV), .TICK_W(TICK_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(timer_load), .load_ticks(load_ticks),
    .expire(expire));

  for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
    always_ff @(posedge clk) begin
      if (!rst_n) rail_en[i] <= 1'b0;
      else if (act && state == ST_UP && up_slot[i] == slot) rail_en[i] <= 1'b1;
      else if (act && state == ST_DOWN && dn_slot[i] == slot) rail_en[i] <= 1'b0;
    end
  end

  assign seq_state = state;

  AST_ON_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ON) |-> (&rail_en));  // R3
  AST_OFF_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OFF) |-> (rail_en == '0));  // R5
  AST_EN_MOVES_ON_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rail_en) |-> $past(act));  // R3
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && state != ST_OFF) |=> (!$stable(cfg_addr) || $stable(cfg_rdata)));  // R9
endmodule

// File: tb/rail_sequencer_test.sv
`timescale 1ns/1ps
module rail_sequencer_test;
  localparam int NR  = 11;
  localparam int DIV = 2;
  localparam int T1 = 3, T2 = 6, T3 = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_req = 1'b0, dn_req = 1'b0, cfg_wr = 1'b0;
  logic [5:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [NR-1:0] en;
  logic [1:0] st;
  logic done;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int tev[NR];
  int tdone;
  int up_s[NR] = '{0, 3, 6, 9, 12, 15, 2, 5, 8, 11, 0};
  int dn_s[NR];
  int up_c[16], dn_c[16];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rail_sequencer #(.NUM_RAILS(NR), .TICK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_up_req(up_req), .pwr_dn_req(dn_req),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .rail_en(en), .seq_state(st), .seq_done(done));

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int ticks(input int code);
    case (code)
      0: return 0;
      1: return T1;
      2: return T2;
      default: return T3;
    endcase
  endfunction

  function automatic int span(input bit up, input int s);
    int acc = 0;
    for (int k = 0; k < s; k++) acc += 1 + ticks(up ? up_c[k] : dn_c[k]) * DIV;
    return acc;
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = 6'(a); cfg_wdata = 8'(d);
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); cfg_addr = 6'(a); #1; d = int'(cfg_rdata);
  endtask

  task automatic pulse(input bit up);
    @(negedge clk); if (up) up_req = 1'b1; else dn_req = 1'b1;
    @(negedge clk); up_req = 1'b0; dn_req = 1'b0;
  endtask

  task automatic load_tables();
    for (int i = 0; i < NR; i++) begin
      wr('h00 + i, up_s[i] << 4);
      wr('h10 + i, dn_s[i] << 4);
    end
    for (int b = 0; b < 4; b++) begin
      wr('h20 + b, (up_c[4*b] << 6) | (up_c[4*b+1] << 4) | (up_c[4*b+2] << 2) | up_c[4*b+3]);
      wr('h28 + b, (dn_c[4*b] << 6) | (dn_c[4*b+1] << 4) | (dn_c[4*b+2] << 2) | dn_c[4*b+3]);
    end
  endtask

  task automatic watch(input bit rising, input int limit);
    for (int i = 0; i < NR; i++) tev[i] = -1;
    tdone = -1;
    for (int n = 0; n < limit; n++) begin
      @(negedge clk);
      for (int i = 0; i < NR; i++)
        if ((rising ? en[i] : !en[i]) && tev[i] < 0) tev[i] = cyc;
      if (done) begin tdone = cyc; break; end
    end
  endtask

  task automatic t_reset();
    int d;
    chk("R1 enables low", int'(en), 0);
    chk("R10 state OFF", int'(st), 0);
    chk("R1 done low", int'(done), 0);
    rd('h03, d); chk("R1 slot field", d, 0);
    rd('h2B, d); chk("R1 wait codes", d, 0);
  endtask

  task automatic t_regs();
    int d;
    wr('h05, 'hF5); rd('h05, d); chk("R2 up slot low nibble", d, 'hF0);
    wr('h1A, 'h7C); rd('h1A, d); chk("R2 down slot", d, 'h70);
    wr('h21, 'hE4); rd('h21, d); chk("R2 wait byte", d, 'hE4);
    rd('h3F, d); chk("R2 unmapped", d, 0);
  endtask

  task automatic t_up();
    load_tables();
    pulse(1'b1);
    watch(1'b1, 2000);
    chk("R6 done seen", int'(tdone >= 0), 1);
    for (int i = 0; i < NR; i++)
      chk($sformatf("R4 rail %0d rise timing", i), tdone - tev[i], span(1'b1, 16) - span(1'b1, up_s[i]) - 1);
    chk("R3 shared slot same cycle", tev[10], tev[0]);
    chk("R3 all on", int'(en), (1 << NR) - 1);
    chk("R10 state ON", int'(st), 2);
    @(negedge clk); chk("R6 done single", int'(done), 0);
  endtask

  task automatic t_ignored_on();
    pulse(1'b1);
    repeat (3) @(negedge clk);
    chk("R8 up in ON ignored", int'(st), 2);
  endtask

  task automatic t_down();
    pulse(1'b0);
    watch(1'b0, 2000);
    chk("R6 done at off", int'(tdone >= 0), 1);
    for (int i = 0; i < NR; i++)
      chk($sformatf("R5 rail %0d fall timing", i), tdone - tev[i], span(1'b0, 16) - span(1'b0, dn_s[i]) - 1);
    chk("R5 all off", int'(en), 0);
    chk("R10 state OFF", int'(st), 0);
    pulse(1'b0);
    repeat (3) @(negedge clk);
    chk("R8 down in OFF ignored", int'(st), 0);
  endtask

  task automatic t_lock();
    int d;
    pulse(1'b1);
    wr('h04, 'hA0);
    rd('h04, d); chk("R9 write during walk", d, up_s[4] << 4);
    watch(1'b1, 2000);
    pulse(1'b0);
    watch(1'b0, 2000);
    rd('h04, d); chk("R9 still locked", d, up_s[4] << 4);
  endtask

  task automatic t_abort();
    int t2 = -1, tclr = -1, td = -1;
    bit r3 = 1'b0;
    for (int i = 0; i < NR; i++) begin up_s[i] = i; dn_s[i] = 0; end
    for (int k = 0; k < 16; k++) begin up_c[k] = 3; dn_c[k] = 0; end
    load_tables();
    pulse(1'b1);
    for (int n = 0; n < 500 && t2 < 0; n++) begin
      @(negedge clk);
      if (en[2]) t2 = cyc;
    end
    dn_req = 1'b1;
    @(negedge clk); dn_req = 1'b0;
    for (int n = 0; n < 500 && td < 0; n++) begin
      if (en[3]) r3 = 1'b1;
      if (!en[0] && tclr < 0) begin
        tclr = cyc;
        up_req = 1'b1;
        @(negedge clk); up_req = 1'b0;
      end else @(negedge clk);
      if (done) td = cyc;
    end
    chk("R7 slot wait honoured", tclr - t2, 1 + T3 * DIV);
    chk("R7 later slot skipped", int'(r3), 0);
    chk("R7 down walk length", td - tclr, 15);
    repeat (3) @(negedge clk);
    chk("R8 up in DOWN ignored", int'(st), 0);
    chk("R5 all off after abort", int'(en), 0);
  endtask

  initial begin
    for (int i = 0; i < NR; i++) dn_s[i] = 15 - i;
    for (int k = 0; k < 16; k++) begin up_c[k] = k % 4; dn_c[k] = (k + 2) % 4; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_up();
    t_ignored_on();
    t_down();
    t_lock();
    t_abort();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule